// File: doc/BRIEF.md
# Sparse Vector Intersection Scorer

The block scores a stream of sparse document vectors against one sparse query vector that sits in an external query store. Every vector is a list of key/value pairs in ascending key order. The block walks the document list and the query list together as a merge-intersection. Each time the two keys are equal, it multiplies the two values and adds the product to the score of the document being processed. The candidate stream only ever moves forward. The query pointer goes back to the first query entry whenever a new document starts.

Input words arrive on a 32-bit valid/ready stream. A word with bit 31 set opens a new document and carries its 31-bit identifier. Any other word is a pair, with the key in bits 30:12 and the value in bits 11:0. A separate end-of-stream beat closes the last open document. A document is closed either by the next identifier word or by an end-of-stream beat. At that point the block emits the identifier together with the raw score on a valid/ready result port. The query store is read through a plain address/data port with a one-cycle read latency. The entries in the store use the same pair layout.

Top module: `svs_scorer`

## Requirements
- R1: For each document, the emitted score is the sum of query value times document value over all keys present in both lists. An identifier word has bit 31 = 1 and carries the id in bits 30:0. A pair word has bit 31 = 0, the key in bits 30:12 and the value in bits 11:0.
- R2: Document pairs whose key does not occur in the query contribute nothing, so a document with no shared key scores 0.
- R3: A document key below the current query key is accepted in the same cycle. An equal key is accepted and the query pointer advances. A greater key is held with in_ready_o low while the query pointer advances one entry per cycle. A fully matching document is accepted one word per cycle with no stall.
- R4: Once every query entry has been passed, the remaining pairs of the document are accepted one per cycle and add nothing.
- R5: Accepting an identifier word presents query address 0, so every document is compared from the first query entry.
- R6: A result is emitted only after an accepted identifier word or end-of-stream beat closes an open document. The data bits of an end-of-stream beat are ignored. An end-of-stream beat with no open document emits nothing.
- R7: While res_valid_o is high and res_ready_i is low, the result identifier and score hold steady. A boundary word that would emit a further result is stalled until the result slot frees, and results leave in stream order.
- R8: The score saturates at the all-ones value of the score width instead of wrapping, and it restarts from 0 for each document.
- R9: Pair words that arrive while no document is open are accepted and discarded, with no effect on any score.
- R10: After reset, res_valid_o is low and no document is open.
- R11: With a query length of 0, every document scores 0 and pairs are accepted without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word or end-of-stream beat is present |
| in_ready_o | output | 1 | Input beat accepted this cycle |
| in_eos_i | input | 1 | Beat is an end-of-stream marker (data ignored) |
| in_data_i | input | 32 | Identifier word or key/value pair |
| q_addr_o | output | AW (11) | Query store read address |
| q_rdata_i | input | 32 | Query entry read one cycle after the address |
| q_len_i | input | AW+1 (12) | Number of valid query entries, capped at the store depth |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result consumer ready |
| res_id_o | output | 31 | Identifier of the scored document |
| res_score_o | output | ACC_W (40) | Raw correlation score, saturating |

## Verification
The assertions check the following on every cycle: that a held result stays steady, that an accepted identifier word puts address 0 on the query port, that a candidate key above the query key is never accepted while query entries remain, that pairs are always accepted once the query is exhausted, that the score never decreases within a document, and that a result appears only after a boundary beat. Only the bench scenarios can show the actual score values, the effect of the rewind on a second document, the exact number of stall cycles, the discarding of orphan pairs and of end-of-stream data, the saturated value, and the order in which results leave under back-pressure.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = WORD_W - 1;

  typedef struct packed {
    logic take;
    logic adv;
    logic rewind;
    logic mac;
    logic open;
    logic close;
  } step_t;
endpackage

// File: rtl/svs_qptr.sv
module svs_qptr #(
  parameter int unsigned QDEPTH = 2048,
  localparam int unsigned AW = $clog2(QDEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          rewind_i,
  input  logic [LW-1:0] q_len_i,
  output logic [AW-1:0] q_addr_o,
  output logic          exh_o
);
  logic [LW-1:0] ptr_q, ptr_d, len_eff;

  always_comb len_eff = (q_len_i > LW'(QDEPTH)) ? LW'(QDEPTH) : q_len_i;

  always_comb begin
    ptr_d = ptr_q;
    if (rewind_i)   ptr_d = '0;
    else if (adv_i) ptr_d = ptr_q + LW'(1);
  end

  // address follows the next pointer so the entry for ptr_q is on the data port
  assign q_addr_o = ptr_d[AW-1:0];
  assign exh_o    = (ptr_q >= len_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/svs_step.sv
module svs_step
  import svs_pkg::*;
#(
  parameter int unsigned KEY_W = 19,
  parameter int unsigned VAL_W = 12
) (
  input  logic              valid_i,
  input  logic              eos_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ID_W-1:0]   qent_i,
  input  logic              doc_open_i,
  input  logic              exh_i,
  input  logic              out_free_i,
  output step_t             step_o
);
  logic             is_id;
  logic [KEY_W-1:0] cand_key, qry_key;

  assign is_id    = word_i[WORD_W-1];
  assign cand_key = word_i[VAL_W +: KEY_W];
  assign qry_key  = qent_i[VAL_W +: KEY_W];

  always_comb begin
    step_o = '0;
    if (valid_i) begin
      if (eos_i || is_id) begin
        step_o.take   = out_free_i || !doc_open_i;
        step_o.close  = step_o.take && doc_open_i;
        step_o.rewind = step_o.take;
        step_o.open   = step_o.take && !eos_i;
      end else if (!doc_open_i || exh_i) begin
        step_o.take = 1'b1;
      end else if (cand_key < qry_key) begin
        step_o.take = 1'b1;
      end else if (cand_key == qry_key) begin
        step_o.take = 1'b1;
        step_o.adv  = 1'b1;
        step_o.mac  = 1'b1;
      end else begin
        step_o.adv = 1'b1;
      end
    end
  end
endmodule

// File: rtl/svs_accum.sv
module svs_accum
  import svs_pkg::*;
#(
  parameter int unsigned VAL_W = 12,
  parameter int unsigned ACC_W = 40,
  localparam int unsigned PROD_W = 2 * VAL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             mac_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [VAL_W-1:0] qval_i,
  input  logic [VAL_W-1:0] cval_i,
  output logic             doc_open_o,
  output logic [ID_W-1:0]  id_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [PROD_W-1:0] prod;
  logic [ACC_W:0]    sum;

  assign prod = PROD_W'(qval_i) * PROD_W'(cval_i);
  assign sum  = {1'b0, acc_o} + (ACC_W+1)'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      doc_open_o <= 1'b0;
      id_o       <= '0;
      acc_o      <= '0;
    end else begin
      if (open_i)       doc_open_o <= 1'b1;
      else if (close_i) doc_open_o <= 1'b0;
      if (open_i) begin
        id_o  <= id_i;
        acc_o <= '0;
      end else if (mac_i) begin
        acc_o <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/svs_result.sv
module svs_result
  import svs_pkg::*;
#(
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [ACC_W-1:0] sc_i,
  input  logic             ready_i,
  output logic             free_o,
  output logic             valid_o,
  output logic [ID_W-1:0]  id_o,
  output logic [ACC_W-1:0] sc_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      id_o    <= '0;
      sc_o    <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      id_o    <= id_i;
      sc_o    <= sc_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/svs_scorer.sv
module svs_scorer
  import svs_pkg::*;
#(
  parameter int unsigned KEY_W  = 19,
  parameter int unsigned VAL_W  = 12,
  parameter int unsigned QDEPTH = 2048,
  parameter int unsigned ACC_W  = 40,
  localparam int unsigned AW = $clog2(QDEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_eos_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic [AW-1:0]     q_addr_o,
  input  logic [WORD_W-1:0] q_rdata_i,
  input  logic [LW-1:0]     q_len_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [ID_W-1:0]   res_id_o,
  output logic [ACC_W-1:0]  res_score_o
);
  step_t            st;
  logic             doc_open_q, q_exh, out_free;
  logic [ID_W-1:0]  id_q;
  logic [ACC_W-1:0] acc_q;
  logic             unused_q_flag;

  assign unused_q_flag = q_rdata_i[WORD_W-1];
  assign in_ready_o    = st.take;

  svs_step #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_step (
    .valid_i    (in_valid_i),
    .eos_i      (in_eos_i),
    .word_i     (in_data_i),
    .qent_i     (q_rdata_i[ID_W-1:0]),
    .doc_open_i (doc_open_q),
    .exh_i      (q_exh),
    .out_free_i (out_free),
    .step_o     (st)
  );

  svs_qptr #(.QDEPTH(QDEPTH)) u_qptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (st.adv),
    .rewind_i (st.rewind),
    .q_len_i  (q_len_i),
    .q_addr_o (q_addr_o),
    .exh_o    (q_exh)
  );

  svs_accum #(.VAL_W(VAL_W), .ACC_W(ACC_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (st.open),
    .close_i    (st.close),
    .mac_i      (st.mac),
    .id_i       (in_data_i[ID_W-1:0]),
    .qval_i     (q_rdata_i[VAL_W-1:0]),
    .cval_i     (in_data_i[VAL_W-1:0]),
    .doc_open_o (doc_open_q),
    .id_o       (id_q),
    .acc_o      (acc_q)
  );

  svs_result #(.ACC_W(ACC_W)) u_result (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (st.close),
    .id_i    (id_q),
    .sc_i    (acc_q),
    .ready_i (res_ready_i),
    .free_o  (out_free),
    .valid_o (res_valid_o),
    .id_o    (res_id_o),
    .sc_o    (res_score_o)
  );
endmodule

// File: rtl/svs_scorer_chk.sv
module svs_scorer_chk #(
  parameter int unsigned KEY_W = 19,
  parameter int unsigned VAL_W = 12,
  parameter int unsigned AW    = 11,
  parameter int unsigned ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             in_eos_i,
  input logic [31:0]      in_data_i,
  input logic [AW-1:0]    q_addr_o,
  input logic [31:0]      q_rdata_i,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [30:0]      res_id_o,
  input logic [ACC_W-1:0] res_score_o,
  input logic             doc_open_i,
  input logic             q_exh_i,
  input logic [ACC_W-1:0] acc_i
);
  logic pair_beat, bound_beat;
  assign pair_beat  = in_valid_i && !in_eos_i && !in_data_i[31];
  assign bound_beat = in_valid_i && in_ready_o && (in_eos_i || in_data_i[31]);

  p_gt_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_beat && doc_open_i && !q_exh_i &&
     (in_data_i[VAL_W +: KEY_W] > q_rdata_i[VAL_W +: KEY_W])) |-> !in_ready_o);

  p_exh_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_beat && q_exh_i) |-> in_ready_o);

  p_rewind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !in_eos_i && in_data_i[31]) |-> (q_addr_o == '0));

  p_emit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(bound_beat));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_id_o) && $stable(res_score_o)));

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_beat && in_ready_o) |=> (acc_i >= $past(acc_i)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r10: assert (!res_valid_o);
    end
  end
endmodule

bind svs_scorer svs_scorer_chk #(
  .KEY_W(KEY_W), .VAL_W(VAL_W), .AW(AW), .ACC_W(ACC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_eos_i    (in_eos_i),
  .in_data_i   (in_data_i),
  .q_addr_o    (q_addr_o),
  .q_rdata_i   (q_rdata_i),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_id_o    (res_id_o),
  .res_score_o (res_score_o),
  .doc_open_i  (doc_open_q),
  .q_exh_i     (q_exh),
  .acc_i       (acc_q)
);

// File: tb/svs_scorer_tb.sv
module svs_scorer_tb;
  localparam int ACC_W = 28;
  localparam longint SAT = (64'd1 << ACC_W) - 1;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_eos = 0, res_ready = 1;
  logic [31:0] in_data = '0;
  logic        in_ready_o;
  logic [10:0] q_addr;
  logic [31:0] q_rdata;
  logic [11:0] q_len = '0;
  logic        res_valid_o;
  logic [30:0] res_id_o;
  logic [ACC_W-1:0] res_score_o;
  logic [31:0] qmem [0:2047];

  int n_chk = 0, n_fail = 0, n_res = 0, stall_cnt = 0;
  logic [30:0]      got_id [0:63];
  logic [ACC_W-1:0] got_sc [0:63];
  int qk[64], qv[64], qn = 0, dk[64], dv[64], dn = 0;

  always #2 clk = ~clk;

  svs_scorer #(.ACC_W(ACC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .in_eos_i(in_eos), .in_data_i(in_data), .q_addr_o(q_addr), .q_rdata_i(q_rdata),
    .q_len_i(q_len), .res_valid_o(res_valid_o), .res_ready_i(res_ready),
    .res_id_o(res_id_o), .res_score_o(res_score_o)
  );

  always_ff @(posedge clk) q_rdata <= qmem[q_addr];

  always @(negedge clk) begin
    if (rst_n && res_valid_o && res_ready && n_res < 64) begin
      got_id[n_res] = res_id_o;
      got_sc[n_res] = res_score_o;
      n_res++;
    end
    if (rst_n && in_valid && !in_ready_o) stall_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_res(input int idx, input int id, input longint sc, input string tag);
    if (idx >= n_res) chk(0, {tag, " result count"}, n_res, idx + 1);
    else begin
      chk(got_id[idx] == 31'(id), {tag, " id"}, got_id[idx], id);
      chk(got_sc[idx] == ACC_W'(sc), {tag, " score"}, got_sc[idx], sc);
    end
  endtask

  task automatic addq(input int k, input int v); qk[qn] = k; qv[qn] = v; qn++; endtask
  task automatic addd(input int k, input int v); dk[dn] = k; dv[dn] = v; dn++; endtask

  function automatic longint ref_sc();
    longint s = 0;
    for (int d = 0; d < dn; d++)
      for (int q = 0; q < qn; q++)
        if (dk[d] == qk[q]) begin
          s += longint'(dv[d]) * longint'(qv[q]);
          if (s > SAT) s = SAT;
        end
    return s;
  endfunction

  task automatic load_q();
    for (int i = 0; i < qn; i++) qmem[i] = {1'b0, qk[i][18:0], qv[i][11:0]};
    q_len = 12'(qn);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [31:0] w, input logic e);
    in_valid = 1; in_data = w; in_eos = e;
    @(negedge clk);
    while (!in_ready_o) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_eos = 0;
  endtask

  task automatic send_doc(input int id);
    send_word({1'b1, 31'(id)}, 1'b0);
    for (int d = 0; d < dn; d++) send_word({1'b0, dk[d][18:0], dv[d][11:0]}, 1'b0);
  endtask

  task automatic drain(); repeat (4) @(negedge clk); endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!res_valid_o, "R10 res_valid after reset", res_valid_o, 0);
    chk(q_addr == '0, "R10 query address after reset", q_addr, 0);
  endtask

  task automatic t_basic();
    int b = n_res; longint ea, eb;
    qn = 0; addq(3, 5); addq(7, 11); addq(12, 2); addq(40, 100); load_q();
    dn = 0; addd(1, 9); addd(3, 6); addd(9, 4); addd(12, 7); addd(50, 3); ea = ref_sc();
    send_doc(32'h101);
    dn = 0; addd(7, 10); addd(40, 20); eb = ref_sc();
    send_doc(32'h102);
    send_word(32'h0, 1'b1); drain();
    chk_res(b, 32'h101, ea, "R1 doc A");
    chk_res(b + 1, 32'h102, eb, "R1 doc B");
  endtask

  task automatic t_disjoint();
    int b = n_res;
    qn = 0; addq(2, 9); addq(4, 9); addq(6, 9); load_q();
    dn = 0; addd(1, 5); addd(3, 5); addd(5, 5); addd(7, 5);
    send_doc(32'h200); send_word(32'h0, 1'b1); drain();
    chk_res(b, 32'h200, 0, "R2 disjoint");
  endtask

  task automatic t_stall();
    int b = n_res, s0;
    qn = 0; for (int k = 1; k <= 8; k++) addq(k, 1); load_q();
    dn = 0; for (int k = 1; k <= 8; k++) addd(k, 2);
    s0 = stall_cnt;
    send_doc(32'h300); send_word(32'h0, 1'b1); drain();
    chk(stall_cnt - s0 == 0, "R3 full match stalls", stall_cnt - s0, 0);
    chk_res(b, 32'h300, 16, "R3 full match");
    qn = 0; addq(1, 1); addq(2, 1); addq(3, 1); addq(10, 9); load_q();
    dn = 0; addd(10, 8);
    s0 = stall_cnt;
    send_doc(32'h301); send_word(32'h0, 1'b1); drain();
    chk(stall_cnt - s0 == 3, "R3 greater key stalls", stall_cnt - s0, 3);
    chk_res(b + 1, 32'h301, 72, "R3 greater key");
  endtask

  task automatic t_exhaust();
    int b = n_res, s0;
    qn = 0; addq(2, 3); addq(4, 5); load_q();
    dn = 0; addd(2, 2); addd(4, 2); for (int k = 5; k <= 9; k++) addd(k, 7);
    s0 = stall_cnt;
    send_doc(32'h400); send_word(32'h0, 1'b1); drain();
    chk(stall_cnt - s0 == 0, "R4 exhausted stalls", stall_cnt - s0, 0);
    chk_res(b, 32'h400, 16, "R4 exhausted");
  endtask

  task automatic t_rewind();
    int b = n_res;
    qn = 0; addq(5, 2); addq(8, 3); addq(20, 4); load_q();
    dn = 0; addd(8, 1); addd(20, 1); send_doc(32'h500);
    dn = 0; addd(5, 1); addd(8, 1); send_doc(32'h501);
    send_word(32'h0, 1'b1); drain();
    chk_res(b, 32'h500, 7, "R5 first doc");
    chk_res(b + 1, 32'h501, 5, "R5 rewound doc");
  endtask

  task automatic t_eos_prefix();
    int b = n_res;
    qn = 0; addq(5, 100); addq(6, 1); load_q();
    send_word(32'hFFFF_FFFF, 1'b1); drain();
    chk(n_res == b, "R6 eos without doc", n_res - b, 0);
    send_word({1'b0, 19'd5, 12'd4000}, 1'b0);
    send_word({1'b1, 31'h55}, 1'b0);
    send_word({1'b0, 19'd6, 12'd3}, 1'b0);
    send_word(32'h8000_0077, 1'b1);
    send_word(32'h8000_0078, 1'b1); drain();
    chk(n_res == b + 1, "R6 one result per closed doc", n_res - b, 1);
    chk_res(b, 32'h55, 3, "R9 orphan pair discarded");
  endtask

  task automatic t_backpressure();
    int b = n_res;
    qn = 0; addq(1, 2); load_q();
    res_ready = 0;
    send_word({1'b1, 31'h11}, 1'b0);
    send_word({1'b0, 19'd1, 12'd3}, 1'b0);
    send_word({1'b1, 31'h22}, 1'b0);
    send_word({1'b0, 19'd1, 12'd5}, 1'b0);
    fork
      send_word(32'h0, 1'b1);
      begin
        repeat (6) @(negedge clk);
        chk(res_valid_o && res_id_o == 31'h11, "R7 held result id", res_id_o, 32'h11);
        chk(res_score_o == ACC_W'(6), "R7 held result score", res_score_o, 6);
        chk(!in_ready_o, "R7 boundary stalled", in_ready_o, 0);
        @(posedge clk); #1;
        res_ready = 1;
      end
    join
    drain();
    chk_res(b, 32'h11, 6, "R7 first out");
    chk_res(b + 1, 32'h22, 10, "R7 second out");
  endtask

  task automatic t_saturate();
    int b = n_res; longint e2;
    qn = 0; for (int k = 1; k <= 20; k++) addq(k, 4095); load_q();
    dn = 0; for (int k = 1; k <= 20; k++) addd(k, 4095);
    chk(ref_sc() == SAT, "R8 model saturates", ref_sc(), SAT);
    send_doc(32'h600);
    dn = 0; addd(1, 4095); addd(2, 4095); e2 = ref_sc();
    send_doc(32'h601);
    send_word(32'h0, 1'b1); drain();
    chk_res(b, 32'h600, SAT, "R8 saturated");
    chk_res(b + 1, 32'h601, e2, "R8 restart after saturation");
  endtask

  task automatic t_qlen0();
    int b = n_res, s0;
    qn = 0; load_q();
    dn = 0; addd(1, 1); addd(2, 2);
    s0 = stall_cnt;
    send_doc(32'h700); send_word(32'h0, 1'b1); drain();
    chk(stall_cnt - s0 == 0, "R11 empty query stalls", stall_cnt - s0, 0);
    chk_res(b, 32'h700, 0, "R11 empty query");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) qmem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_disjoint();
    t_stall();
    t_exhaust();
    t_rewind();
    t_eos_prefix();
    t_backpressure();
    t_saturate();
    t_qlen0();
    summary();
    $finish;
  end
endmodule